// File: doc/BRIEF.md
# Programmable Frequency Output Prescaler

This block derives a slow, programmable clock-like output from one of several timing sources. A chain of digit counters, driven by the crystal input, provides a set of scaler taps. Each tap runs a fixed factor slower than the one before it. Software picks whether each digit counts in tens or in sixteens. A source selector then chooses the crystal, an external source pin, a gate pin or a scaler tap. A final integer divider turns the edges of the chosen source into a square wave on `fout`.

All inputs are levels sampled by `clk`. They are assumed to be already synchronous to it and to stay high for at least one clock and low for at least one clock. Only a low-to-high change of an input counts as one source period. The mode register is loaded in parallel by `mode_we` and `mode_wdata`. A load also restarts both the output divider and the scaler chain, so every ratio begins from a known phase.

The output divider is a three-state machine with the states OFF, LOW and HIGH:
- Reset enters OFF.
- A mode load with the off bit set enters OFF.
- A mode load with the off bit clear enters LOW, with the phase count cleared.
- LOW goes to HIGH once its phase length of source edges has been seen.
- HIGH goes to LOW once its own phase length of edges has been seen.
- For a ratio of one, HIGH goes to LOW on the very next clock.

Top module: `fout_prescaler`

## Requirements
- R1: After reset, `fout` and every `tap_out` bit are low, and the mode register holds 0x1000, so the output stays low until a mode load.
- R2: With mode bit 15 clear, tap k (k = 0..4, `tap_out[k]`) pulses for one clock on every 16^k-th crystal rising edge counted from the last mode load (tap 0 on every edge, tap 4 on every 65536th).
- R3: With mode bit 15 set, tap k pulses on every 10^k-th crystal rising edge counted from the last mode load (tap 4 on every 10000th).
- R4: Mode bits 7:4 choose the source: 0 is `xtal_in`; 1 to 5 are `src_in[0]` to `src_in[4]`; 6 to 10 are `gate_in[0]` to `gate_in[4]`; 11 to 15 are taps 0 to 4.
- R5: Mode bits 11:8 give the output ratio D in source periods. The values 1 to 15 mean that value, and 0 means 16. For example, mode 0x8500 on a 1.536 MHz crystal gives 307200 Hz and 0x8A00 gives 153600 Hz.
- R6: After a load, `fout` is low for D - floor(D/2) source edges and then high for floor(D/2) source edges, repeating. For D = 1 it goes high for one clock after each source edge.
- R7: While mode bit 12 is set, `fout` is held low whatever the inputs do.
- R8: A mode load drives `fout` low on the next clock and restarts the divider phase and all scaler counters from zero.
- R9: Only rising edges of the selected source advance the divider. Activity on any unselected input has no effect on `fout`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_we | input | 1 | Load strobe for the mode register |
| mode_wdata | input | 16 | Value loaded into the mode register |
| xtal_in | input | 1 | Crystal-derived timing input, base of the scaler chain |
| src_in | input | 5 | External source inputs 1 to 5 |
| gate_in | input | 5 | Gate inputs 1 to 5, usable as sources |
| fout | output | 1 | Divided frequency output |
| tap_out | output | 5 | One-clock strobes of the scaler taps |

## Verification
The bench builds the block with its defaults: five taps and five source and five gate inputs, which fills the 16-code selector exactly. At these sizes every selector code and every divisor class can be reached: one, odd, even and the zero-means-sixteen case. The decade chain can be run out to its last tap at 10000 crystal edges. In hex stepping, the run length reaches tap 3 (4096 edges) and not the 65536-edge last tap, so the deepest hex digit is covered by the same generated stage logic that the shallower stages exercise.

// File: rtl/fout_pkg.sv
package fout_pkg;

    localparam int MODE_W     = 16;
    localparam int SEL_W      = 4;
    localparam int DIV_W      = 4;

    // Mode register field positions
    localparam int MB_DECADE  = 15;
    localparam int MB_OFF     = 12;
    localparam int MB_DIV_LSB = 8;
    localparam int MB_SEL_LSB = 4;

    localparam logic [MODE_W-1:0] MODE_AT_RESET = 16'h1000;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_LOW  = 2'd1,
        ST_HIGH = 2'd2
    } div_state_t;

endpackage

// File: rtl/fout_edge_detect.sv
module fout_edge_detect #(
    parameter int W = 11
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] level,
    output logic [W-1:0] rise
);

    logic [W-1:0] level_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            level_q <= '0;
        end else begin
            level_q <= level;
        end
    end

    assign rise = level & ~level_q;

endmodule

// File: rtl/fout_scaler_chain.sv
module fout_scaler_chain #(
    parameter int NUM_TAPS = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                restart,
    input  logic                decade,
    input  logic                base_tick,
    output logic [NUM_TAPS-1:0] tap_tick
);

    localparam int STAGES = NUM_TAPS - 1;

    logic [3:0] wrap_at;

    assign wrap_at     = decade ? 4'd9 : 4'd15;
    assign tap_tick[0] = base_tick;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        logic [3:0] digit_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                digit_q <= '0;
            end else if (restart) begin
                digit_q <= '0;
            end else if (tap_tick[g]) begin
                digit_q <= (digit_q >= wrap_at) ? 4'd0 : digit_q + 4'd1;
            end
        end

        assign tap_tick[g+1] = tap_tick[g] & (digit_q >= wrap_at);

        // R3: in decade stepping no digit ever leaves 0..9
        p_decade_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
            decade |-> (digit_q <= 4'd9));
    end

endmodule

// File: rtl/fout_source_mux.sv
module fout_source_mux #(
    parameter int NUM_EXT  = 5,
    parameter int NUM_TAPS = 5
) (
    input  logic [3:0]          sel,
    input  logic                xtal_tick,
    input  logic [NUM_EXT-1:0]  src_tick,
    input  logic [NUM_EXT-1:0]  gate_tick,
    input  logic [NUM_TAPS-1:0] tap_tick,
    output logic                sel_tick
);

    localparam int VEC_W = 1 + 2 * NUM_EXT + NUM_TAPS;

    logic [15:0] cand;

    assign cand     = 16'({tap_tick, gate_tick, src_tick, xtal_tick});
    assign sel_tick = cand[sel];

endmodule

// File: rtl/fout_out_divider.sv
module fout_out_divider
    import fout_pkg::*;
#(
    parameter int DIV_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             restart_off,
    input  logic [DIV_W-1:0] divisor,
    input  logic             src_tick,
    output logic             fout
);

    localparam int                 RATIO_W = DIV_W + 1;
    localparam logic [RATIO_W-1:0] ONE     = RATIO_W'(1);

    div_state_t         state_q, state_d;
    logic [RATIO_W-1:0] cnt_q, cnt_d;
    logic [RATIO_W-1:0] ratio, hi_len, lo_len;

    always_comb begin
        ratio  = (divisor == '0) ? {1'b1, {DIV_W{1'b0}}} : {1'b0, divisor};
        hi_len = ratio >> 1;
        lo_len = ratio - hi_len;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (restart) begin
            state_d = restart_off ? ST_OFF : ST_LOW;
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                ST_OFF: begin
                end
                ST_LOW: begin
                    if (src_tick) begin
                        if (cnt_q == lo_len - ONE) begin
                            state_d = ST_HIGH;
                            cnt_d   = '0;
                        end else begin
                            cnt_d = cnt_q + ONE;
                        end
                    end
                end
                ST_HIGH: begin
                    if (hi_len == '0) begin
                        state_d = ST_LOW;
                        cnt_d   = '0;
                    end else if (src_tick) begin
                        if (cnt_q == hi_len - ONE) begin
                            state_d = ST_LOW;
                            cnt_d   = '0;
                        end else begin
                            cnt_d = cnt_q + ONE;
                        end
                    end
                end
                default: begin
                    state_d = ST_OFF;
                    cnt_d   = '0;
                end
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Outputs
    always_comb begin
        fout = (state_q == ST_HIGH);
    end

    // R8: a load always leaves the output low
    p_restart_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !fout);

    // R6: ratio one gives a single-clock high pulse
    p_pulse_one_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (divisor == DIV_W'(1) && fout && !restart) |=> !fout);

    // R9: the output only rises after a selected source edge
    p_rise_on_tick_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fout) |-> $past(src_tick));

endmodule

// File: rtl/fout_prescaler.sv
module fout_prescaler
    import fout_pkg::*;
#(
    parameter int NUM_EXT  = 5,
    parameter int NUM_TAPS = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                mode_we,
    input  logic [15:0]         mode_wdata,
    input  logic                xtal_in,
    input  logic [NUM_EXT-1:0]  src_in,
    input  logic [NUM_EXT-1:0]  gate_in,
    output logic                fout,
    output logic [NUM_TAPS-1:0] tap_out
);

    localparam int IN_W = 1 + 2 * NUM_EXT;

    logic [MODE_W-1:0] mode_q;
    logic [IN_W-1:0]   in_rise;
    logic              sel_tick;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= MODE_AT_RESET;
        end else if (mode_we) begin
            mode_q <= mode_wdata;
        end
    end

    fout_edge_detect #(.W(IN_W)) u_edges (
        .clk   (clk),
        .rst_n (rst_n),
        .level ({gate_in, src_in, xtal_in}),
        .rise  (in_rise)
    );

    fout_scaler_chain #(.NUM_TAPS(NUM_TAPS)) u_chain (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (mode_we),
        .decade    (mode_q[MB_DECADE]),
        .base_tick (in_rise[0]),
        .tap_tick  (tap_out)
    );

    fout_source_mux #(.NUM_EXT(NUM_EXT), .NUM_TAPS(NUM_TAPS)) u_mux (
        .sel       (mode_q[MB_SEL_LSB +: SEL_W]),
        .xtal_tick (in_rise[0]),
        .src_tick  (in_rise[NUM_EXT:1]),
        .gate_tick (in_rise[IN_W-1:NUM_EXT+1]),
        .tap_tick  (tap_out),
        .sel_tick  (sel_tick)
    );

    fout_out_divider #(.DIV_W(DIV_W)) u_div (
        .clk         (clk),
        .rst_n       (rst_n),
        .restart     (mode_we),
        .restart_off (mode_wdata[MB_OFF]),
        .divisor     (mode_q[MB_DIV_LSB +: DIV_W]),
        .src_tick    (sel_tick),
        .fout        (fout)
    );

    // R7: output disabled by the off bit stays low
    p_off_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mode_q[MB_OFF] |-> !fout);

endmodule

// File: tb/tb_fout_prescaler.sv
module tb_fout_prescaler;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_we = 1'b0;
    logic [15:0] mode_wdata = '0;
    logic [10:0] lvl = '0;   // [0] xtal, [5:1] src1..5, [10:6] gate1..5
    logic        fout;
    logic [4:0]  tap_out;

    int n_checks = 0;
    int n_err    = 0;
    int rises    = 0;
    int highs    = 0;
    int tap_cnt [5];
    logic prev_out = 1'b0;
    bit   done = 1'b0;

    always #10 clk = ~clk;

    fout_prescaler dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_we    (mode_we),
        .mode_wdata (mode_wdata),
        .xtal_in    (lvl[0]),
        .src_in     (lvl[5:1]),
        .gate_in    (lvl[10:6]),
        .fout       (fout),
        .tap_out    (tap_out)
    );

    // mode, source edges, expected rises, expected high samples
    localparam int NV = 13;
    localparam logic [63:0] VEC [NV] = '{
        {16'h8500, 16'd10,    16'd2, 16'd8},
        {16'h8A00, 16'd20,    16'd2, 16'd20},
        {16'h0000, 16'd32,    16'd2, 16'd32},
        {16'h0100, 16'd5,     16'd5, 16'd5},
        {16'h0300, 16'd9,     16'd3, 16'd6},
        {16'h82C0, 16'd40,    16'd2, 16'd40},
        {16'h02C0, 16'd64,    16'd2, 16'd64},
        {16'h1500, 16'd10,    16'd0, 16'd0},
        {16'h81B0, 16'd4,     16'd4, 16'd4},
        {16'h00D0, 16'd4096,  16'd1, 16'd4096},
        {16'h81E0, 16'd2000,  16'd2, 16'd2},
        {16'h81F0, 16'd10000, 16'd1, 16'd1},
        {16'h01E0, 16'd4096,  16'd1, 16'd1}
    };

    task automatic check_eq(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic clear_counts();
        rises = 0;
        highs = 0;
        for (int k = 0; k < 5; k++) tap_cnt[k] = 0;
        prev_out = fout;
    endtask

    task automatic sample_out();
        if (fout) highs++;
        if (fout && !prev_out) rises++;
        prev_out = fout;
    endtask

    // Called at a falling edge; returns at a falling edge with inputs low
    task automatic stim_period(input int idx);
        lvl[idx] = 1'b1;
        #1;
        for (int k = 0; k < 5; k++) if (tap_out[k]) tap_cnt[k]++;
        @(negedge clk);
        sample_out();
        lvl[idx] = 1'b0;
        @(negedge clk);
        sample_out();
    endtask

    task automatic run_periods(input int idx, input int n);
        for (int j = 0; j < n; j++) stim_period(idx);
    endtask

    task automatic write_mode(input logic [15:0] m);
        mode_we    = 1'b1;
        mode_wdata = m;
        @(negedge clk);
        mode_we = 1'b0;
        clear_counts();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check_eq("R1 fout after reset", int'(fout), 0);
        check_eq("R1 taps after reset", int'(tap_out), 0);
        clear_counts();
        run_periods(0, 20);
        check_eq("R1 reset mode keeps output off", rises, 0);

        // Vector table: R4 R5 R6 R7 (ratios, duty, sources, off)
        for (int i = 0; i < NV; i++) begin
            write_mode(VEC[i][63:48]);
            run_periods(0, int'(VEC[i][47:32]));
            check_eq($sformatf("R5 R6 vec%0d rises", i), rises, int'(VEC[i][31:16]));
            check_eq($sformatf("R5 R6 vec%0d high samples", i), highs, int'(VEC[i][15:0]));
        end

        // R2: hex stepping taps
        write_mode(16'h1000);
        run_periods(0, 256);
        check_eq("R2 tap0", tap_cnt[0], 256);
        check_eq("R2 tap1", tap_cnt[1], 16);
        check_eq("R2 tap2", tap_cnt[2], 1);
        check_eq("R2 tap3", tap_cnt[3], 0);
        check_eq("R7 off output never high", highs, 0);

        // R3: decade stepping taps
        write_mode(16'h9000);
        run_periods(0, 100);
        check_eq("R3 tap0", tap_cnt[0], 100);
        check_eq("R3 tap1", tap_cnt[1], 10);
        check_eq("R3 tap2", tap_cnt[2], 1);
        check_eq("R3 tap3", tap_cnt[3], 0);

        // R9: unselected inputs ignored, then SRC3 drives the divider (R4)
        write_mode(16'h0230);
        run_periods(0, 6);
        run_periods(1, 6);
        run_periods(8, 6);
        check_eq("R9 unselected inputs no rise", rises, 0);
        clear_counts();
        run_periods(3, 4);
        check_eq("R4 src3 rises", rises, 2);
        check_eq("R4 src3 high samples", highs, 4);

        // R4: GATE3 source, ratio 3
        write_mode(16'h0380);
        run_periods(8, 3);
        check_eq("R4 gate3 rises", rises, 1);
        check_eq("R4 gate3 high samples", highs, 2);

        // R8: load in the middle of a high phase restarts the phase
        write_mode(16'h0400);
        run_periods(0, 3);
        check_eq("R6 high after two edges", int'(fout), 1);
        write_mode(16'h0400);
        check_eq("R8 low right after load", int'(fout), 0);
        run_periods(0, 1);
        check_eq("R8 still low after one edge", int'(fout), 0);
        run_periods(0, 1);
        check_eq("R8 high after two edges from load", int'(fout), 1);

        // R7: turning off while high
        write_mode(16'h1400);
        check_eq("R7 low after off load", int'(fout), 0);
        run_periods(0, 10);
        check_eq("R7 no rises while off", rises, 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
        $finish;
    end

endmodule